// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Memory

This block is a shared word memory with two identical access ports, called left and right, both running on one system clock. Each port has an address, a write data bus, a read data bus, and four active-low controls: select, write, output enable and busy. Any location can be written and read from either port.

The two highest addresses also act as mailboxes between the ports. The all-ones address is the right port's inbox. When the left port writes it, the right interrupt output goes low. When the right port reads it, that interrupt goes high again. The all-ones-minus-one address is the left port's inbox and works the same way in the other direction. A mailbox access also stores or returns the word, like any other location, so a message can be passed along with the interrupt.

Each interrupt is held by a two-state machine: `MB_EMPTY` (output high) and `MB_FULL` (output low). The transitions are:
- `EMPTY->FULL` on a qualifying write by the peer port.
- `FULL->EMPTY` on a qualifying read by the owning port, provided no write arrives in the same cycle.
- Otherwise the state holds (`EMPTY->EMPTY`, `FULL->FULL`).

The address width is a parameter. A width of 15 gives a 32K-word array, and the default of 10 keeps the model small.

Top module: `dpmbox_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `lt_irq_n` and `rt_irq_n` are both 1 (state `MB_EMPTY`).
- R2: A left-port write (`lt_cs_n`=0, `lt_we_n`=0, `lt_busy_n`=1) to the all-ones address moves the right flag to `MB_FULL`. `rt_irq_n` is 0 from the cycle after the sampling clock edge.
- R3: A right-port read (`rt_cs_n`=0, `rt_we_n`=1, `rt_oe_n`=0, `rt_busy_n`=1) of the all-ones address moves the right flag to `MB_EMPTY`. `rt_irq_n` is 1 from the next cycle.
- R4: In the mirror case, a right-port write to the all-ones-minus-one address drives `lt_irq_n` to 0, and a left-port read of that address returns it to 1, with the same timing as R2 and R3.
- R5: An access that would set or clear a flag leaves the flag unchanged when the accessing port's busy input is 0.
- R6: When the set and the clear of one flag fall in the same cycle, the set wins and the interrupt output is 0 afterwards.
- R7: A write stores `wdata` at `addr`, mailbox addresses included. A read (select 0, write 1, output enable 0) presents the stored word on `rdata` one cycle after the sampling edge, and `rdata` holds its value when no read is made.
- R8: None of the following changes a flag:
  - a port writing its own inbox;
  - a port reading the peer's inbox;
  - a read made with output enable at 1.
- R9: When both ports write the same address in one cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lt_addr | input | ADDR_W | Left word address |
| lt_cs_n | input | 1 | Left select, active low |
| lt_we_n | input | 1 | Left write strobe, active low (1 = read) |
| lt_oe_n | input | 1 | Left output enable, active low |
| lt_busy_n | input | 1 | Left busy, active low; blocks left flag effects |
| lt_wdata | input | DATA_W | Left write data |
| lt_rdata | output | DATA_W | Left read data, registered |
| lt_irq_n | output | 1 | Left interrupt, active low |
| rt_addr | input | ADDR_W | Right word address |
| rt_cs_n | input | 1 | Right select, active low |
| rt_we_n | input | 1 | Right write strobe, active low (1 = read) |
| rt_oe_n | input | 1 | Right output enable, active low |
| rt_busy_n | input | 1 | Right busy, active low; blocks right flag effects |
| rt_wdata | input | DATA_W | Right write data |
| rt_rdata | output | DATA_W | Right read data, registered |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
Two functions can fall in the same clock edge on one flag: the peer's mailbox write, which sets it, and the owner's mailbox read, which clears it. The bench provokes this by driving both ports onto the same inbox in one cycle, once with the flag already full and once with it empty. In both cases it expects the interrupt to be low afterwards. The returned read word is judged against the value stored before that cycle, since a read sees the old contents. A second collision, both ports writing one ordinary address, is judged by reading back the left port's word.

// File: rtl/dpmbox_pkg.sv
package dpmbox_pkg;

    typedef enum logic {
        MB_EMPTY = 1'b0,
        MB_FULL  = 1'b1
    } mb_state_e;

    typedef struct packed {
        logic wr;
        logic rd;
    } port_req_t;

    localparam int NUM_PORTS = 2;

endpackage

// File: rtl/dpmbox_port_dec.sv
module dpmbox_port_dec
    import dpmbox_pkg::*;
#(
    parameter int                ADDR_W  = 10,
    parameter logic [ADDR_W-1:0] IN_MBX  = '0,
    parameter logic [ADDR_W-1:0] OUT_MBX = '0
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy_n,
    input  logic [ADDR_W-1:0] addr,
    output port_req_t         req,
    output logic              raise_peer,
    output logic              ack_own
);

    always_comb begin
        req.wr     = !cs_n && !we_n;
        req.rd     = !cs_n && we_n && !oe_n;
        // write to the peer's inbox raises the peer's interrupt
        raise_peer = req.wr && busy_n && (addr == OUT_MBX);
        // read of own inbox acknowledges own interrupt
        ack_own    = req.rd && busy_n && (addr == IN_MBX);
    end

endmodule

// File: rtl/dpmbox_flag.sv
module dpmbox_flag
    import dpmbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    mb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_EMPTY: if (set_i) state_d = MB_FULL;
            MB_FULL:  if (clr_i && !set_i) state_d = MB_EMPTY;
            default:  state_d = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n_o = (state_q != MB_FULL);
    end

endmodule

// File: rtl/dpmbox_mem.sv
module dpmbox_mem
    import dpmbox_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PORTS-1:0]                wr_en,
    input  logic [NUM_PORTS-1:0]                rd_en,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    wdata,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // highest index first so that port 0 (left) is applied last and wins
    always_ff @(posedge clk) begin
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (wr_en[p]) mem[addr[p]] <= wdata[p];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        rdata[p] <= '0;
            else if (rd_en[p]) rdata[p] <= mem[addr[p]];
        end
    end

endmodule

// File: rtl/dpmbox_top.sv
module dpmbox_top
    import dpmbox_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              lt_cs_n,
    input  logic              lt_we_n,
    input  logic              lt_oe_n,
    input  logic              lt_busy_n,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_irq_n,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              rt_cs_n,
    input  logic              rt_we_n,
    input  logic              rt_oe_n,
    input  logic              rt_busy_n,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_irq_n
);

    // inbox of port 1 (right) is all ones, inbox of port 0 (left) is one below
    localparam logic [ADDR_W-1:0] MBX_RT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MBX_LT = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [NUM_PORTS-1:0][ADDR_W-1:0] p_addr;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_wdata;
    logic [NUM_PORTS-1:0][DATA_W-1:0] p_rdata;
    logic [NUM_PORTS-1:0]             p_cs_n, p_we_n, p_oe_n, p_busy_n;
    logic [NUM_PORTS-1:0]             p_wr, p_rd, p_raise, p_ack, p_irq_n;
    port_req_t                        p_req [NUM_PORTS];

    always_comb begin
        p_addr   = {rt_addr, lt_addr};
        p_wdata  = {rt_wdata, lt_wdata};
        p_cs_n   = {rt_cs_n, lt_cs_n};
        p_we_n   = {rt_we_n, lt_we_n};
        p_oe_n   = {rt_oe_n, lt_oe_n};
        p_busy_n = {rt_busy_n, lt_busy_n};
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] IN_A  = (p == 0) ? MBX_LT : MBX_RT;
        localparam logic [ADDR_W-1:0] OUT_A = (p == 0) ? MBX_RT : MBX_LT;

        dpmbox_port_dec #(
            .ADDR_W (ADDR_W),
            .IN_MBX (IN_A),
            .OUT_MBX(OUT_A)
        ) u_dec (
            .cs_n      (p_cs_n[p]),
            .we_n      (p_we_n[p]),
            .oe_n      (p_oe_n[p]),
            .busy_n    (p_busy_n[p]),
            .addr      (p_addr[p]),
            .req       (p_req[p]),
            .raise_peer(p_raise[p]),
            .ack_own   (p_ack[p])
        );

        assign p_wr[p] = p_req[p].wr;
        assign p_rd[p] = p_req[p].rd;

        dpmbox_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (p_raise[NUM_PORTS-1-p]),
            .clr_i  (p_ack[p]),
            .irq_n_o(p_irq_n[p])
        );
    end

    dpmbox_mem #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(p_wr),
        .rd_en(p_rd),
        .addr (p_addr),
        .wdata(p_wdata),
        .rdata(p_rdata)
    );

    assign lt_rdata = p_rdata[0];
    assign rt_rdata = p_rdata[1];
    assign lt_irq_n = p_irq_n[0];
    assign rt_irq_n = p_irq_n[1];

endmodule

// File: rtl/dpmbox_chk.sv
module dpmbox_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lt_addr,
    input logic              lt_cs_n,
    input logic              lt_we_n,
    input logic              lt_oe_n,
    input logic              lt_busy_n,
    input logic [DATA_W-1:0] lt_wdata,
    input logic [DATA_W-1:0] lt_rdata,
    input logic              lt_irq_n,
    input logic [ADDR_W-1:0] rt_addr,
    input logic              rt_cs_n,
    input logic              rt_we_n,
    input logic              rt_oe_n,
    input logic              rt_busy_n,
    input logic [DATA_W-1:0] rt_wdata,
    input logic [DATA_W-1:0] rt_rdata,
    input logic              rt_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic set_r, clr_r, set_l, clr_l;
    logic unused_ok;

    assign set_r = !lt_cs_n && !lt_we_n && (lt_addr == BOX_R) && lt_busy_n;
    assign clr_r = !rt_cs_n && rt_we_n && !rt_oe_n && (rt_addr == BOX_R) && rt_busy_n;
    assign set_l = !rt_cs_n && !rt_we_n && (rt_addr == BOX_L) && rt_busy_n;
    assign clr_l = !lt_cs_n && lt_we_n && !lt_oe_n && (lt_addr == BOX_L) && lt_busy_n;
    assign unused_ok = ^{lt_wdata, lt_rdata, rt_wdata, rt_rdata};

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (lt_irq_n && rt_irq_n)); // R1
    AST_RT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_r |=> !rt_irq_n); // R2
    AST_RT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !set_r) |=> rt_irq_n); // R3
    AST_LT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_l |=> !lt_irq_n); // R4
    AST_LT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_l && !set_l) |=> lt_irq_n); // R4
    AST_RT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_r && !clr_r) |=> $stable(rt_irq_n)); // R5
    AST_LT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_l && !clr_l) |=> $stable(lt_irq_n)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_r && clr_r) |=> !rt_irq_n); // R6

endmodule

bind dpmbox_top dpmbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpmbox_top_tb.sv
module dpmbox_top_tb;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 16;
    localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_cs_n = 1'b1, lt_we_n = 1'b1, lt_oe_n = 1'b1, lt_busy_n = 1'b1;
    logic rt_cs_n = 1'b1, rt_we_n = 1'b1, rt_oe_n = 1'b1, rt_busy_n = 1'b1;
    logic [DATA_W-1:0] lt_wdata = '0, rt_wdata = '0;
    logic [DATA_W-1:0] lt_rdata, rt_rdata;
    logic lt_irq_n, rt_irq_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dpmbox_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (.*);

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        lt_cs_n = 1; lt_we_n = 1; lt_oe_n = 1; lt_busy_n = 1;
        rt_cs_n = 1; rt_we_n = 1; rt_oe_n = 1; rt_busy_n = 1;
    endtask

    // each access: drive at a falling edge, sampled at the next rising edge,
    // return at the following falling edge where results are visible
    task automatic lt_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic bsy_n);
        @(negedge clk);
        lt_addr = a; lt_wdata = d; lt_cs_n = 0; lt_we_n = 0; lt_busy_n = bsy_n;
        @(negedge clk);
        idle_all();
    endtask

    task automatic rt_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic bsy_n);
        @(negedge clk);
        rt_addr = a; rt_wdata = d; rt_cs_n = 0; rt_we_n = 0; rt_busy_n = bsy_n;
        @(negedge clk);
        idle_all();
    endtask

    task automatic lt_read(input logic [ADDR_W-1:0] a, input logic oe, input logic bsy_n);
        @(negedge clk);
        lt_addr = a; lt_cs_n = 0; lt_we_n = 1; lt_oe_n = oe; lt_busy_n = bsy_n;
        @(negedge clk);
        idle_all();
    endtask

    task automatic rt_read(input logic [ADDR_W-1:0] a, input logic oe, input logic bsy_n);
        @(negedge clk);
        rt_addr = a; rt_cs_n = 0; rt_we_n = 1; rt_oe_n = oe; rt_busy_n = bsy_n;
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_reset();
        check("R1 lt_irq_n in reset", 16'(lt_irq_n), 16'd1);
        check("R1 rt_irq_n in reset", 16'(rt_irq_n), 16'd1);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        check("R1 lt_irq_n after release", 16'(lt_irq_n), 16'd1);
        check("R1 rt_irq_n after release", 16'(rt_irq_n), 16'd1);
    endtask

    task automatic t_memory();
        lt_write(10'h005, 16'h1234, 1);
        lt_write(10'h2A0, 16'hA5A5, 1);
        rt_write(10'h000, 16'h0F0F, 1);
        rt_read(10'h005, 0, 1);
        check("R7 right reads left word", rt_rdata, 16'h1234);
        lt_read(10'h000, 0, 1);
        check("R7 left reads right word", lt_rdata, 16'h0F0F);
        rt_read(10'h2A0, 0, 1);
        check("R7 second address", rt_rdata, 16'hA5A5);
        repeat (2) @(negedge clk);
        check("R7 rdata holds without read", rt_rdata, 16'hA5A5);
        lt_read(10'h005, 1, 1);
        check("R7 oe high keeps rdata", lt_rdata, 16'h0F0F);
    endtask

    task automatic t_right_box();
        lt_write(BOX_R, 16'hBEEF, 1);
        check("R2 rt_irq_n set", 16'(rt_irq_n), 16'd0);
        check("R8 lt_irq_n untouched", 16'(lt_irq_n), 16'd1);
        rt_read(BOX_R, 0, 1);
        check("R7 mailbox word", rt_rdata, 16'hBEEF);
        check("R3 rt_irq_n cleared", 16'(rt_irq_n), 16'd1);
    endtask

    task automatic t_left_box();
        rt_write(BOX_L, 16'hC0DE, 1);
        check("R4 lt_irq_n set", 16'(lt_irq_n), 16'd0);
        check("R4 rt_irq_n untouched", 16'(rt_irq_n), 16'd1);
        lt_read(BOX_L, 0, 1);
        check("R4 mailbox word", lt_rdata, 16'hC0DE);
        check("R4 lt_irq_n cleared", 16'(lt_irq_n), 16'd1);
    endtask

    task automatic t_no_effect();
        lt_write(BOX_L, 16'h1111, 1);
        check("R8 own-inbox write left", 16'(lt_irq_n), 16'd1);
        rt_write(BOX_R, 16'h2222, 1);
        check("R8 own-inbox write right", 16'(rt_irq_n), 16'd1);
        lt_write(BOX_R, 16'h3333, 1);
        lt_read(BOX_R, 0, 1);
        check("R8 writer reads peer inbox", 16'(rt_irq_n), 16'd0);
        rt_read(BOX_R, 1, 1);
        check("R8 read with oe high", 16'(rt_irq_n), 16'd0);
        rt_read(BOX_R, 0, 1);
        check("R3 clear after no-effect", 16'(rt_irq_n), 16'd1);
    endtask

    task automatic t_busy();
        lt_write(BOX_R, 16'h4444, 0);
        check("R5 busy blocks set", 16'(rt_irq_n), 16'd1);
        rt_write(BOX_L, 16'h5555, 0);
        check("R5 busy blocks set left", 16'(lt_irq_n), 16'd1);
        lt_write(BOX_R, 16'h6666, 1);
        rt_read(BOX_R, 0, 0);
        check("R5 busy blocks clear", 16'(rt_irq_n), 16'd0);
        rt_read(BOX_R, 0, 1);
        check("R3 clear after busy", 16'(rt_irq_n), 16'd1);
    endtask

    task automatic t_collide();
        lt_write(BOX_R, 16'h7777, 1);
        @(negedge clk);
        lt_addr = BOX_R; lt_wdata = 16'h8888; lt_cs_n = 0; lt_we_n = 0;
        rt_addr = BOX_R; rt_cs_n = 0; rt_we_n = 1; rt_oe_n = 0;
        @(negedge clk);
        idle_all();
        check("R6 set wins when full", 16'(rt_irq_n), 16'd0);
        check("R7 read sees old word", rt_rdata, 16'h7777);
        rt_read(BOX_R, 0, 1);
        check("R3 clear before second collision", 16'(rt_irq_n), 16'd1);
        @(negedge clk);
        lt_addr = BOX_R; lt_wdata = 16'h9999; lt_cs_n = 0; lt_we_n = 0;
        rt_addr = BOX_R; rt_cs_n = 0; rt_we_n = 1; rt_oe_n = 0;
        @(negedge clk);
        idle_all();
        check("R6 set wins when empty", 16'(rt_irq_n), 16'd0);
        rt_read(BOX_R, 0, 1);
        check("R6 final clear", 16'(rt_irq_n), 16'd1);
    endtask

    task automatic t_same_addr();
        @(negedge clk);
        lt_addr = 10'h033; lt_wdata = 16'hAAAA; lt_cs_n = 0; lt_we_n = 0;
        rt_addr = 10'h033; rt_wdata = 16'h5555; rt_cs_n = 0; rt_we_n = 0;
        @(negedge clk);
        idle_all();
        rt_read(10'h033, 0, 1);
        check("R9 left data kept", rt_rdata, 16'hAAAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_memory();
        t_right_box();
        t_left_box();
        t_no_effect();
        t_busy();
        t_collide();
        t_same_addr();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule